// File: doc/BRIEF.md
# Receive Interrupt Coalescer

This block sits beside a network receive path and decides when the host should be interrupted. Every completed frame arrives as a one-cycle strobe with its length. Frames that pass a size test are grouped into a bundle. The block raises its interrupt request when the bundle reaches a programmable frame count. It also raises the request when a watchdog countdown runs out while frames are still waiting.

Short frames, such as transport acknowledgements, skip the bundle and interrupt at once. This avoids stalling a sender that is waiting for them. The size test ANDs the frame length with a programmable bit mask: a zero result marks the frame as short.

Software sets three 16-bit tuning words through a small write port: the countdown reload value, the bundle frame limit and the size mask. The countdown advances only on cycles where an external prescaler tick is high. The request is a level. It stays high until the host pulses the acknowledge input.

Top module: `rx_irq_coalescer`

## Requirements
- R1: Synchronous reset drives irq_req low, empties the bundle, stops the countdown and loads the defaults: reload 0x0600, frame limit 6, size mask 0xFF80. With these defaults a 127-byte frame interrupts at once, and the sixth consecutive 128-byte frame interrupts.
- R2: A frame whose length ANDed with the size mask equals zero sets irq_req at the clock edge that samples its strobe.
- R3: A short frame leaves the bundle untouched: its frame count and its countdown keep their values.
- R4: A frame that passes the size test adds one to the bundle count. When the count reaches the frame limit, irq_req is set at that edge and the bundle is emptied. A limit of 0 or 1 interrupts on every such frame.
- R5: A frame limit of 0xFFFF turns off the count limit, so only the countdown can close a bundle.
- R6: The first frame of an empty bundle loads the countdown with the reload value. Each tick with the countdown running lowers it by one. The tick that brings it to zero, while frames are pending, sets irq_req and empties the bundle. A reload of 0 expires on the first tick.
- R7: Once set, irq_req stays high until a cycle with irq_ack high, and falls at that edge. If a new interrupt cause occurs in the same cycle as the acknowledge, irq_req stays high. Frames that arrive while irq_req is high start or extend a new bundle.
- R8: A write with cfg_addr 0 sets the reload value, 1 sets the frame limit and 2 sets the size mask, each from the next cycle on. A write with cfg_addr 3 changes nothing.
- R9: When a short frame and a bundle-closing event fall in the same cycle, the block produces a single interrupt and the bundle still closes.
- R10: Ticks with an empty bundle never raise irq_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Tuning word write strobe |
| cfg_addr | input | 2 | Tuning word select: 0 reload, 1 frame limit, 2 size mask |
| cfg_wdata | input | 16 | Tuning word value |
| tick | input | 1 | Prescaler enable for the countdown |
| frame_done | input | 1 | One-cycle receive-complete strobe |
| frame_len | input | 16 | Length in bytes of the completed frame |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_req | output | 1 | Interrupt request level |

## Verification
The bound checker checks on every cycle that:
- the request holds until it is acknowledged;
- an acknowledge clears the request when no new cause occurs in that cycle;
- a short frame always raises the request and leaves the count unchanged on a cycle without a tick;
- a count-limit hit empties the bundle;
- idle cycles with an empty bundle never raise the request.

Some behaviour needs a sequence of events, so only the bench scenarios can show it:
- the exact tick on which the countdown expires;
- the count resuming across an intervening short frame;
- an unlimited bundle that only the countdown can close;
- a countdown expiry coinciding with a short frame, which must still empty the bundle.

A cycle model in the bench, driven by seeded random traffic and random tuning writes, follows the request on every cycle.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int NUM_CFG = 3;

  typedef enum logic [1:0] {
    CFG_RELOAD = 2'd0,
    CFG_LIMIT  = 2'd1,
    CFG_MASK   = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/coal_cfg_regs.sv
module coal_cfg_regs
  import coal_pkg::*;
#(
  parameter int DW = 16,
  parameter logic [DW-1:0] RELOAD_DEF = 16'h0600,
  parameter logic [DW-1:0] LIMIT_DEF  = 16'd6,
  parameter logic [DW-1:0] MASK_DEF   = 16'hFF80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] reload,
  output logic [DW-1:0] limit,
  output logic [DW-1:0] mask
);
  logic [DW-1:0] word_q [NUM_CFG];
  logic [DW-1:0] def_w  [NUM_CFG];

  assign def_w[0] = RELOAD_DEF;
  assign def_w[1] = LIMIT_DEF;
  assign def_w[2] = MASK_DEF;

  // One register per tuning word; the select value 3 matches none of them.
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
    localparam logic [1:0] SEL = 2'(i);
    always_ff @(posedge clk) begin
      if (rst)                      word_q[i] <= def_w[i];
      else if (we && addr == SEL)   word_q[i] <= wdata;
    end
  end

  assign reload = word_q[CFG_RELOAD];
  assign limit  = word_q[CFG_LIMIT];
  assign mask   = word_q[CFG_MASK];
endmodule

// File: rtl/coal_bundle.sv
module coal_bundle #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          join_frame,
  input  logic          tick,
  input  logic [DW-1:0] limit,
  input  logic [DW-1:0] reload,
  output logic          close_evt,
  output logic [DW-1:0] count
);
  localparam logic [DW-1:0] ALL_ONES = '1;

  logic [DW-1:0] cnt_q, tmr_q, cnt_inc;
  logic          run_q, count_hit, tmr_hit;

  assign cnt_inc   = (cnt_q == ALL_ONES) ? cnt_q : cnt_q + 1'b1;
  assign count_hit = join_frame && (limit != ALL_ONES) && (cnt_inc >= limit);
  assign tmr_hit   = run_q && tick && (tmr_q <= DW'(1));
  assign close_evt = count_hit || tmr_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tmr_q <= '0;
      run_q <= 1'b0;
    end else if (close_evt) begin
      cnt_q <= '0;
      tmr_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (join_frame) cnt_q <= cnt_inc;
      if (join_frame && cnt_q == '0) begin
        tmr_q <= reload;
        run_q <= 1'b1;
      end else if (run_q && tick) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/coal_irq.sv
module coal_irq (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic ack,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)       irq <= 1'b0;
    else if (fire) irq <= 1'b1;
    else if (ack)  irq <= 1'b0;
  end
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer #(
  parameter int DW = 16,
  parameter logic [DW-1:0] RELOAD_DEF = 16'h0600,
  parameter logic [DW-1:0] LIMIT_DEF  = 16'd6,
  parameter logic [DW-1:0] MASK_DEF   = 16'hFF80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          tick,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_len,
  input  logic          irq_ack,
  output logic          irq_req
);
  logic [DW-1:0] cfg_reload, cfg_limit, cfg_mask, bundle_cnt;
  logic          short_frame, close_evt;

  coal_cfg_regs #(
    .DW(DW), .RELOAD_DEF(RELOAD_DEF), .LIMIT_DEF(LIMIT_DEF), .MASK_DEF(MASK_DEF)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .reload(cfg_reload), .limit(cfg_limit), .mask(cfg_mask)
  );

  assign short_frame = frame_done && ((frame_len & cfg_mask) == '0);

  coal_bundle #(.DW(DW)) u_bundle (
    .clk(clk), .rst(rst),
    .join_frame(frame_done && !short_frame),
    .tick(tick), .limit(cfg_limit), .reload(cfg_reload),
    .close_evt(close_evt), .count(bundle_cnt)
  );

  coal_irq u_irq (
    .clk(clk), .rst(rst),
    .fire(short_frame || close_evt),
    .ack(irq_ack), .irq(irq_req)
  );
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_done,
  input logic [DW-1:0] frame_len,
  input logic          tick,
  input logic          irq_ack,
  input logic          irq_req,
  input logic [DW-1:0] mask,
  input logic [DW-1:0] limit,
  input logic [DW-1:0] bcnt
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (!irq_req && bcnt == '0));

  p_short_fires_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_done && (frame_len & mask) == '0) |=> irq_req);

  p_short_keeps_count_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_done && (frame_len & mask) == '0 && !tick) |=> $stable(bcnt));

  p_limit_empties_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_done && (frame_len & mask) != '0 && limit != '1 &&
     (bcnt + 1'b1) >= limit && bcnt != '1) |=> (bcnt == '0 && irq_req));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> irq_req);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack && !frame_done && !tick) |=> !irq_req);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && !frame_done && bcnt == '0) |=> !irq_req);
endmodule

bind rx_irq_coalescer coal_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .frame_done(frame_done), .frame_len(frame_len),
  .tick(tick), .irq_ack(irq_ack), .irq_req(irq_req),
  .mask(cfg_mask), .limit(cfg_limit), .bcnt(bundle_cnt)
);

// File: tb/rx_irq_coalescer_bench.sv
module rx_irq_coalescer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        tick = 1'b0;
  logic        frame_done = 1'b0;
  logic [15:0] frame_len = '0;
  logic        irq_ack = 1'b0;
  logic        irq_req;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_irq_coalescer u_rx_irq_coalescer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick(tick), .frame_done(frame_done),
    .frame_len(frame_len), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // Reference model built from the requirements
  logic [15:0] m_reload, m_limit, m_mask, m_cnt, m_tmr;
  logic        m_run, m_irq;

  function automatic bit is_short(input logic [15:0] len, input logic [15:0] msk);
    return (len & msk) == 16'h0;
  endfunction

  function automatic logic [15:0] sat_inc(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reload <= 16'h0600; m_limit <= 16'd6; m_mask <= 16'hFF80;
      m_cnt <= '0; m_tmr <= '0; m_run <= 1'b0; m_irq <= 1'b0;
    end else begin
      bit sh, joins, hit_c, hit_t;
      sh    = frame_done && is_short(frame_len, m_mask);
      joins = frame_done && !sh;
      hit_c = joins && m_limit != 16'hFFFF && sat_inc(m_cnt) >= m_limit;
      hit_t = m_run && tick && m_tmr <= 16'd1;
      if (cfg_we && cfg_addr == 2'd0) m_reload <= cfg_wdata;
      if (cfg_we && cfg_addr == 2'd1) m_limit  <= cfg_wdata;
      if (cfg_we && cfg_addr == 2'd2) m_mask   <= cfg_wdata;
      if (hit_c || hit_t) begin
        m_cnt <= '0; m_tmr <= '0; m_run <= 1'b0;
      end else begin
        if (joins) m_cnt <= sat_inc(m_cnt);
        if (joins && m_cnt == 0) begin m_tmr <= m_reload; m_run <= 1'b1; end
        else if (m_run && tick) m_tmr <= m_tmr - 16'd1;
      end
      if (sh || hit_c || hit_t) m_irq <= 1'b1;
      else if (irq_ack)         m_irq <= 1'b0;
    end
  end

  // Cycle-by-cycle comparison of the request level against the model (R2,R4,R6,R7)
  always @(negedge clk) begin
    if (!rst && !done) begin
      tests++;
      if (irq_req !== m_irq) begin
        fails++;
        $display("FAIL model R7 t=%0t irq_req=%0b expected=%0b", $time, irq_req, m_irq);
      end
    end
  end

  task automatic check(input string req, input logic exp);
    tests++;
    if (irq_req !== exp) begin
      fails++;
      $display("FAIL %s irq_req=%0b expected=%0b", req, irq_req, exp);
    end
  endtask

  task automatic cyc(input bit fd, input logic [15:0] len, input bit tk, input bit ak);
    frame_done = fd; frame_len = len; tick = tk; irq_ack = ak; cfg_we = 1'b0;
    @(negedge clk);
    frame_done = 1'b0; tick = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    frame_done = 1'b0; tick = 1'b0; irq_ack = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0A1));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", 1'b0);

    // R2 / R1: default mask, 127 bytes is short
    cyc(1, 16'd127, 0, 0); check("R2 short default", 1'b1);
    repeat (3) begin cyc(0, 0, 0, 0); check("R7 hold", 1'b1); end
    cyc(0, 0, 0, 1); check("R7 ack", 1'b0);

    // R4 / R1: default limit 6 with 128-byte frames
    for (int i = 0; i < 5; i++) begin cyc(1, 16'd128, 0, 0); check("R4 below limit", 1'b0); end
    cyc(1, 16'd128, 0, 0); check("R4 limit reached", 1'b1);
    cyc(0, 0, 0, 1); check("R7 ack", 1'b0);

    // R3: short frame in the middle leaves the count alone
    for (int i = 0; i < 3; i++) cyc(1, 16'd200, 0, 0);
    cyc(1, 16'd10, 0, 0); check("R3 short irq", 1'b1);
    cyc(0, 0, 0, 1); check("R3 ack", 1'b0);
    cyc(1, 16'd200, 0, 0); cyc(1, 16'd200, 0, 0); check("R3 count kept", 1'b0);
    cyc(1, 16'd200, 0, 0); check("R3 sixth frame", 1'b1);
    cyc(0, 0, 0, 1);

    // R6: countdown of 4 ticks
    wr(2'd0, 16'd4);
    cyc(1, 16'd300, 0, 0);
    for (int i = 0; i < 3; i++) begin cyc(0, 0, 1, 0); check("R6 before expiry", 1'b0); end
    cyc(0, 0, 1, 0); check("R6 expiry", 1'b1);
    cyc(0, 0, 0, 1); check("R6 ack", 1'b0);

    // R10: ticks with empty bundle
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0);
    check("R10 idle ticks", 1'b0);

    // R5: unlimited count
    wr(2'd1, 16'hFFFF);
    for (int i = 0; i < 20; i++) cyc(1, 16'd500, 0, 0);
    check("R5 no count close", 1'b0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
    check("R5 timer pending", 1'b0);
    cyc(0, 0, 1, 0); check("R5 timer closes", 1'b1);
    cyc(0, 0, 0, 1);

    // R8: write port decoding
    wr(2'd1, 16'd2);
    wr(2'd3, 16'd7);
    cyc(1, 16'd600, 0, 0); check("R8 limit 2 first", 1'b0);
    cyc(1, 16'd600, 0, 0); check("R8 addr3 ignored", 1'b1);
    cyc(0, 0, 0, 1);
    wr(2'd2, 16'hFFFF);
    cyc(1, 16'd5, 0, 0); check("R8 mask FFFF bundles", 1'b0);
    cyc(1, 16'd5, 0, 0); check("R8 mask FFFF count", 1'b1);
    cyc(0, 0, 0, 1);
    wr(2'd2, 16'hF800);
    cyc(1, 16'd2000, 0, 0); check("R2 mask F800", 1'b1);
    cyc(0, 0, 0, 1);
    wr(2'd2, 16'hFF80);

    // R7: ack together with a new cause
    cyc(1, 16'd10, 0, 0);
    cyc(1, 16'd10, 0, 1); check("R7 ack with fire", 1'b1);
    cyc(0, 0, 0, 1); check("R7 ack", 1'b0);

    // R9: short frame coinciding with countdown expiry
    wr(2'd0, 16'd2);
    cyc(1, 16'd400, 0, 0);
    cyc(0, 0, 1, 0);
    cyc(1, 16'd20, 1, 0); check("R9 single irq", 1'b1);
    cyc(0, 0, 0, 1); check("R9 ack", 1'b0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0);
    check("R9 bundle closed", 1'b0);
    cyc(1, 16'd400, 0, 0); check("R9 count restarted", 1'b0);
    cyc(1, 16'd400, 0, 0); check("R9 count hit", 1'b1);
    cyc(0, 0, 0, 1);

    // Seeded random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(99) < 3) begin
        logic [1:0]  a;
        logic [15:0] d;
        a = 2'($urandom_range(3));
        case (a)
          2'd0: d = 16'($urandom_range(12, 0));
          2'd1: d = ($urandom_range(7) == 0) ? 16'hFFFF : 16'($urandom_range(8, 0));
          2'd2: case ($urandom_range(3))
                  0: d = 16'hFF80; 1: d = 16'hFFFF; 2: d = 16'hF800; default: d = 16'hFFC0;
                endcase
          default: d = 16'($urandom);
        endcase
        wr(a, d);
      end else begin
        cyc($urandom_range(99) < 40, 16'($urandom_range(1599)),
            $urandom_range(99) < 30, $urandom_range(99) < 15);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule